// File: doc/BRIEF.md
# DRAM Burst Column Address Generator

This block supplies the column address for every data beat of one read or write burst to a DRAM whose row and column addresses share pins. A small mode register, written through `mode_wr`, holds the burst length and the burst ordering. A one-cycle `start` pulse with a start column launches a burst. One column address then appears on every clock cycle, flagged by `col_valid`, and `col_last` marks the final beat. Four fixed lengths are available: 2, 4 and 8 beats, plus a full page of 256 columns. Ordering is either sequential or interleaved.

A full-page burst runs in sequential order from an even column. It ends when `term` is raised, and otherwise after one full pass of the page. A start that asks for a full page with interleaved order, or a full page from an odd column, is refused: the block raises `mode_err` for one cycle and produces no beats.

The sequencer is a three-state machine:
- **IDLE**: waits for a start. IDLE→RUN on a legal start. IDLE→REJECT on an illegal start.
- **RUN**: presents one beat per cycle. RUN→RUN while the current beat is not the last. RUN→IDLE on the last beat.
- **REJECT**: lasts one cycle and drives `mode_err`. REJECT→IDLE always.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `mode_err` are low. The mode register holds length code 00 (2 beats) with sequential order.
- R2: When `mode_wr` is high at a rising clock edge, the mode register loads the length code from `mode_len` and the order from `mode_ilv`. Length codes: 00 = 2 beats, 01 = 4, 10 = 8, 11 = full page. Order: 0 = sequential, 1 = interleave.
- R3: A legal `start` sampled at a rising edge while IDLE produces beats on the following cycles, one per cycle with no gaps, beginning in the cycle right after that edge. The first beat carries `start_col` unchanged.
- R4: For 2-, 4- and 8-beat sequential bursts, the low log2(BL) bits of the column count up modulo BL from those of the start column. The higher bits stay equal to the start column's.
- R5: For interleaved bursts of 2, 4 and 8 beats, beat i carries the start column's low log2(BL) bits XOR i. The higher bits stay unchanged.
- R6: A full-page sequential burst from an even column increments the column modulo 256. If `term` is never raised, it delivers exactly 256 beats.
- R7: During a full-page burst, a beat presented while `term` is high is the final beat of that burst.
- R8: A start while the length code is 11 and the order is interleave produces no beats. `mode_err` is high for exactly the one cycle after that start edge.
- R9: A full-page start from an odd `start_col` produces no beats. `mode_err` is high for exactly the one cycle after that start edge.
- R10: `col_last` is high on the final beat of every burst and on no other beat. `col_valid` is low in the cycle after the final beat.
- R11: While a burst is running, `start` and mode writes do not change the running burst's addresses or length. Mode writes still take effect for the next burst.
- R12: `term` has no effect on 2-, 4- or 8-beat bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Loads the mode register |
| mode_len | input | 2 | Length code for a mode write |
| mode_ilv | input | 1 | Order for a mode write (1 = interleave) |
| start | input | 1 | Launches a burst when idle |
| start_col | input | 8 | First column of the burst |
| term | input | 1 | Ends a full-page burst on the current beat |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | The current beat is the final one |
| mode_err | output | 1 | One-cycle pulse for a refused start |

## Verification
The bench first runs sequential bursts of each fixed length from start columns that sit mid-block. These show whether the block wraps inside the aligned block or carries into the higher bits. Interleaved bursts from the same kind of columns separate XOR ordering from addition. Full-page runs show whether the column wraps past 255 and whether termination by count or by `term` ends the burst on the right beat. Refused starts, repeated starts and mode writes during a burst, and `term` raised during short bursts show whether anything that should be ignored leaks into the beat stream.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        BL_2    = 2'b00,
        BL_4    = 2'b01,
        BL_8    = 2'b10,
        BL_PAGE = 2'b11
    } blen_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } border_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_RUN    = 2'b01,
        ST_REJECT = 2'b10
    } bstate_e;

    typedef struct packed {
        blen_e   len;
        border_e ord;
    } bmode_t;

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       len_in,
    input  logic             ilv_in,
    output bmode_t           mode,
    output logic [COL_W-1:0] wrap_mask,
    output logic             page
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode.len <= BL_2;
            mode.ord <= ORD_SEQ;
        end else if (wr) begin
            mode.len <= blen_e'(len_in);
            mode.ord <= border_e'(ilv_in);
        end
    end

    always_comb begin
        unique case (mode.len)
            BL_2:    wrap_mask = COL_W'(1);
            BL_4:    wrap_mask = COL_W'(3);
            BL_8:    wrap_mask = COL_W'(7);
            BL_PAGE: wrap_mask = '1;
        endcase
    end

    assign page = (mode.len == BL_PAGE);

    a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mode.len == blen_e'($past(len_in)) && mode.ord == border_e'($past(ilv_in))));

endmodule

// File: rtl/bcg_check.sv
module bcg_check
    import bcg_pkg::*;
(
    input  bmode_t mode,
    input  logic   start_lsb,
    output logic   legal
);

    logic page_sel;

    always_comb begin
        page_sel = (mode.len == BL_PAGE);
        legal    = !(page_sel && ((mode.ord == ORD_ILV) || start_lsb));
    end

endmodule

// File: rtl/bcg_fsm.sv
module bcg_fsm
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             term,
    input  logic [COL_W-1:0] start_col,
    input  logic             legal,
    input  logic [COL_W-1:0] mask_in,
    input  border_e          ord_in,
    input  logic             page_in,
    output logic             busy,
    output logic             reject,
    output logic             last,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] mask,
    output border_e          ord
);

    bstate_e state, nxt;
    logic    page;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = legal ? ST_RUN : ST_REJECT;
            ST_RUN:    if (last)  nxt = ST_IDLE;
            ST_REJECT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // burst snapshot and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
            cnt  <= '0;
            mask <= COL_W'(1);
            ord  <= ORD_SEQ;
            page <= 1'b0;
        end else if (state == ST_IDLE && start && legal) begin
            base <= start_col;
            cnt  <= '0;
            mask <= mask_in;
            ord  <= ord_in;
            page <= page_in;
        end else if (state == ST_RUN && !last) begin
            cnt <= cnt + COL_W'(1);
        end
    end

    // outputs
    always_comb begin
        busy   = (state == ST_RUN);
        reject = (state == ST_REJECT);
        last   = busy && ((cnt == mask) || (page && term));
    end

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (state == ST_RUN && cnt == $past(cnt) + COL_W'(1)));

    a_r10_end: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (state != ST_RUN));

    a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= mask));

    a_r8_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (state == ST_IDLE));

endmodule

// File: rtl/bcg_addr.sv
module bcg_addr
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  border_e          ord,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low;

    always_comb begin
        low = (ord == ORD_ILV) ? (base ^ cnt) : (base + cnt);
        col = (base & ~mask) | (low & mask);
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [1:0]       mode_len,
    input  logic             mode_ilv,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             term,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             mode_err
);

    bmode_t           mode;
    logic [COL_W-1:0] wrap_mask;
    logic             page_sel;
    logic             legal;
    logic [COL_W-1:0] base, cnt, run_mask;
    border_e          run_ord;

    bcg_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr(mode_wr), .len_in(mode_len),
        .ilv_in(mode_ilv), .mode(mode), .wrap_mask(wrap_mask), .page(page_sel)
    );

    bcg_check u_check (
        .mode(mode), .start_lsb(start_col[0]), .legal(legal)
    );

    bcg_fsm #(.COL_W(COL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .term(term),
        .start_col(start_col), .legal(legal), .mask_in(wrap_mask),
        .ord_in(mode.ord), .page_in(page_sel), .busy(col_valid),
        .reject(mode_err), .last(col_last), .base(base), .cnt(cnt),
        .mask(run_mask), .ord(run_ord)
    );

    bcg_addr #(.COL_W(COL_W)) u_addr (
        .base(base), .cnt(cnt), .mask(run_mask), .ord(run_ord), .col(col_addr)
    );

    a_r10_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    a_r8_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !col_valid);

    a_r11_no_break: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last) |=> col_valid);

    a_r4_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last) |=> ((col_addr & ~run_mask) == ($past(col_addr) & ~run_mask)));

endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

    typedef struct {
        logic [7:0] col;
        logic       last;
        string      tag;
    } beat_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_len = 2'b00;
    logic       mode_ilv = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = 8'h00;
    logic       term = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid, col_last, mode_err;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    beat_t sb[$];

    always #10 clk = ~clk;

    burst_col_gen dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_len(mode_len),
        .mode_ilv(mode_ilv), .start(start), .start_col(start_col), .term(term),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
        .mode_err(mode_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_col(int s, int len, int ilv, int i);
        int n, blk, off;
        n   = (len == 0) ? 2 : (len == 1) ? 4 : (len == 2) ? 8 : 256;
        off = s % n;
        blk = s - off;
        if (ilv != 0) return 8'(blk + (off ^ i));
        return 8'(blk + ((off + i) % n));
    endfunction

    // monitor: pop and compare each presented beat
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && col_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected beat", col_addr, 0);
                end else begin
                    beat_t e;
                    e = sb.pop_front();
                    check(col_addr == e.col, e.tag, col_addr, e.col);
                    check(col_last == e.last, "R10 last flag", col_last, e.last);
                end
            end
        end
    end

    task automatic write_mode(input int len, input int ilv);
        @(negedge clk);
        mode_wr  = 1'b1;
        mode_len = 2'(len);
        mode_ilv = 1'(ilv);
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wait_drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // term_at < 0: no term; nbeats: beats the bench expects
    task automatic run_burst(input int s, input int len, input int ilv,
                             input int term_at, input int nbeats, input string tag);
        for (int i = 0; i < nbeats; i++) begin
            beat_t b;
            b.col  = exp_col(s, len, ilv, i);
            b.last = (i == nbeats - 1);
            b.tag  = tag;
            sb.push_back(b);
        end
        @(negedge clk);
        start     = 1'b1;
        start_col = 8'(s);
        @(negedge clk);
        start = 1'b0;
        if (term_at >= 0) begin
            repeat (term_at) @(negedge clk);
            term = 1'b1;
            @(negedge clk);
            term = 1'b0;
        end
        wait_drain();
    endtask

    task automatic reject_case(input int s, input string tag);
        @(negedge clk);
        start     = 1'b1;
        start_col = 8'(s);
        @(negedge clk);
        start = 1'b0;
        #1;
        check(mode_err == 1'b1, tag, mode_err, 1);
        check(col_valid == 1'b0, tag, col_valid, 0);
        @(negedge clk);
        #1;
        check(mode_err == 1'b0, tag, mode_err, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(col_valid == 1'b0, "R1 valid in reset", col_valid, 0);
        check(col_last == 1'b0, "R1 last in reset", col_last, 0);
        check(mode_err == 1'b0, "R1 err in reset", mode_err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(col_valid == 1'b0 && mode_err == 1'b0, "R1 idle after reset", col_valid, 0);

        // R1: default mode is 2-beat sequential
        run_burst(8'h35, 0, 0, -1, 2, "R1 default mode");

        // R2 R4: sequential bursts from mid-block columns
        write_mode(1, 0);
        run_burst(8'h4E, 1, 0, -1, 4, "R4 seq BL4");
        write_mode(2, 0);
        run_burst(8'h9D, 2, 0, -1, 8, "R4 seq BL8");
        run_burst(8'h20, 2, 0, -1, 8, "R3 seq BL8 aligned");

        // R5: interleave
        write_mode(0, 1);
        run_burst(8'h11, 0, 1, -1, 2, "R5 ilv BL2");
        write_mode(1, 1);
        run_burst(8'h62, 1, 1, -1, 4, "R5 ilv BL4");
        write_mode(2, 1);
        run_burst(8'hAB, 2, 1, -1, 8, "R5 ilv BL8");

        // R12: term during short burst ignored
        run_burst(8'h05, 2, 1, 1, 8, "R12 term ignored");

        // R8: page with interleave refused
        write_mode(3, 1);
        reject_case(8'h10, "R8 page ilv refused");

        // R9 R6 R7: page sequential
        write_mode(3, 0);
        reject_case(8'h33, "R9 page odd refused");
        run_burst(8'h40, 3, 0, -1, 256, "R6 page full pass");
        run_burst(8'hFE, 3, 0, 5, 6, "R7 page term wrap");
        run_burst(8'h80, 3, 0, 0, 1, "R7 page term first beat");

        // R11: start and mode write during a running burst
        write_mode(2, 0);
        for (int i = 0; i < 8; i++) begin
            beat_t b;
            b.col  = exp_col(8'h13, 2, 0, i);
            b.last = (i == 7);
            b.tag  = "R11 busy start ignored";
            sb.push_back(b);
        end
        @(negedge clk);
        start     = 1'b1;
        start_col = 8'h13;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        start     = 1'b1;
        start_col = 8'h70;
        mode_wr   = 1'b1;
        mode_len  = 2'b01;
        mode_ilv  = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        mode_wr = 1'b0;
        wait_drain();
        // R11: the mode written mid-burst applies to the next burst
        run_burst(8'h72, 1, 1, -1, 4, "R11 new mode next burst");

        check(sb.size() == 0, "R3 queue drained", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule